// File: doc/BRIEF.md
# Bridge control register file

A bank of 28 thirty-two-bit control words sitting on a simple word-addressed bus. The bus presents a word address (the byte offset divided by four), a write strobe and write data; read data is returned combinationally for whatever word address is presented. Most words are plain storage that reads back what was last written, starting from fixed power-on values.

Three words carry behaviour. The interrupt-enable word cannot be written directly; software sets bits in it through one alias word and clears bits through another, so that two agents can modify different enable bits without a read-modify-write. The interrupt-status word shows an external pending-interrupt vector and ignores bus writes. The general configuration word emits a one-cycle system reset request whenever a write raises its bit 2 from 0 to 1.

Top module: `bridge_ctrl_regs`

## Requirements
- R1: After reset, words read back these values (word address in brackets): [0] 0x00000C40, [1] 0x00001384, [2] 0x2BFF8010, [3] 0x255E0091, [4] 0x00006140, [7] 0x000001FF, [8] 0x000001FF, [26] 0x00000008, [27] 0x10000000; every other word in 0..27, including the enable word [14] and status word [15], reads 0.
- R2: A write to any word in 0..27 other than [14] and [15] is stored and read back unchanged on the next cycle.
- R3: A write to the set alias [12] stores the value in [12] and ORs it into the enable word [14].
- R4: A write to the clear alias [13] stores the value in [13] and clears in [14] every bit that is 1 in the written value.
- R5: Writes to the enable word [14] and the status word [15] have no effect.
- R6: The status word [15] reads the value `irq_pending` had at the previous clock edge.
- R7: A write to the configuration word [1] whose data has bit 2 set while the stored bit 2 is 0 drives `sys_rst_pulse` high for exactly the one cycle after the write; the written value is still stored.
- R8: A write to [1] while its stored bit 2 is already 1, or with data bit 2 clear, leaves `sys_rst_pulse` low.
- R9: Word addresses 28..31 are unmapped: writes there change nothing and reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 5 | Word address (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_pending | input | 32 | Pending-interrupt vector loaded into the status word |
| sys_rst_pulse | output | 1 | One-cycle system reset request |

## Verification
The enable word is driven by overlapping set and clear patterns, so a set alias that overwrote instead of OR-ing, or a clear alias that cleared unwritten bits, yields a different enable value. The reset request is exercised with the configuration bit already high from reset, cleared, raised and raised again, which separates edge detection from level detection. Writes aimed at the enable, status and unmapped words are each followed by a read of the touched word, and plain storage is tried with alternating, all-ones and all-zero data at the low, middle and last mapped words.

// File: rtl/bridge_ctrl_regs.sv
module bridge_ctrl_regs #(
  parameter int DATA_W    = 32,
  parameter int NUM_WORDS = 28,
  parameter int ADDR_W    = 5,
  parameter int GEN_IDX   = 1,
  parameter int RST_BIT   = 2,
  parameter int SET_IDX   = 12,
  parameter int CLR_IDX   = 13,
  parameter int EN_IDX    = 14,
  parameter int STAT_IDX  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] irq_pending,
  output logic              sys_rst_pulse
);

  localparam logic [ADDR_W-1:0] A_GEN  = ADDR_W'(GEN_IDX);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(SET_IDX);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(CLR_IDX);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(EN_IDX);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_IDX);

  function automatic logic [DATA_W-1:0] dflt(input int i);
    case (i)
      0:       return DATA_W'(32'h0000_0C40);
      1:       return DATA_W'(32'h0000_1384);
      2:       return DATA_W'(32'h2BFF_8010);
      3:       return DATA_W'(32'h255E_0091);
      4:       return DATA_W'(32'h0000_6140);
      7:       return DATA_W'(32'h0000_01FF);
      8:       return DATA_W'(32'h0000_01FF);
      26:      return DATA_W'(32'h0000_0008);
      27:      return DATA_W'(32'h1000_0000);
      default: return '0;
    endcase
  endfunction

  logic [DATA_W-1:0] store_q [NUM_WORDS];
  logic [DATA_W-1:0] en_q, stat_q;
  logic              pulse_q;

  wire in_map = {1'b0, bus_addr} < (ADDR_W+1)'(NUM_WORDS);
  wire hit    = bus_wr && in_map;
  wire rise   = hit && bus_addr == A_GEN && !store_q[GEN_IDX][RST_BIT] && bus_wdata[RST_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WORDS; i++) store_q[i] <= dflt(i);
      en_q    <= '0;
      stat_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      stat_q  <= irq_pending;
      pulse_q <= rise;
      if (hit && bus_addr != A_EN && bus_addr != A_STAT) store_q[bus_addr] <= bus_wdata;
      if (hit && bus_addr == A_SET) en_q <= en_q | bus_wdata;
      else if (hit && bus_addr == A_CLR) en_q <= en_q & ~bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (in_map) begin
      if (bus_addr == A_EN)        bus_rdata = en_q;
      else if (bus_addr == A_STAT) bus_rdata = stat_q;
      else                         bus_rdata = store_q[bus_addr];
    end
  end

  assign sys_rst_pulse = pulse_q;

  assert_set_or_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_SET) |=> ((en_q & $past(bus_wdata)) == $past(bus_wdata)));

  assert_clr_and_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CLR) |=> ((en_q & $past(bus_wdata)) == '0));

  assert_en_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && (bus_addr == A_SET || bus_addr == A_CLR)) |=> $stable(en_q));

  assert_stat_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (stat_q == $past(irq_pending)));

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_pulse |=> !sys_rst_pulse);

  assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_pulse) |-> $past(bus_wr && bus_addr == A_GEN && bus_wdata[RST_BIT]));

  always_comb if (rst_n && !in_map) assert_unmapped_zero_R9: assert (bus_rdata == '0);

endmodule

// File: tb/tb_bridge_ctrl_regs.sv
`timescale 1ns/1ps
module tb_bridge_ctrl_regs;
  logic        clk = 0, rst_n = 0, bus_wr = 0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, irq_pending = '0;
  logic [31:0] bus_rdata;
  logic        sys_rst_pulse;

  bridge_ctrl_regs dut (.clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
                        .irq_pending, .sys_rst_pulse);

  always #2 clk = ~clk;

  typedef struct { bit is_pulse; logic [4:0] a; logic [31:0] exp; string req; } item_t;
  item_t q[$];
  int n_chk = 0, n_bad = 0;
  logic chk_en = 0;
  bit finished = 0;

  always @(negedge clk) if (chk_en && q.size() > 0) begin
    item_t it;
    logic [31:0] act;
    it = q.pop_front();
    act = it.is_pulse ? {31'b0, sys_rst_pulse} : bus_rdata;
    n_chk++;
    if (act !== it.exp) begin
      n_bad++;
      $display("FAIL %s %s word %0d: actual %h expected %h", it.req,
               it.is_pulse ? "pulse" : "read", it.a, act, it.exp);
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string r);
    item_t it;
    bus_addr = a;
    it.is_pulse = 0; it.a = a; it.exp = e; it.req = r;
    q.push_back(it);
    chk_en = 1; tick(); chk_en = 0;
  endtask

  task automatic pl(input bit e, input string r);
    item_t it;
    it.is_pulse = 1; it.a = 5'd1; it.exp = {31'b0, e}; it.req = r;
    q.push_back(it);
    chk_en = 1; tick(); chk_en = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(); tick(); rst_n = 1; tick();
    // R1 reset defaults
    rd(0, 32'h0000_0C40, "R1"); rd(1, 32'h0000_1384, "R1");
    rd(2, 32'h2BFF_8010, "R1"); rd(3, 32'h255E_0091, "R1");
    rd(4, 32'h0000_6140, "R1"); rd(7, 32'h0000_01FF, "R1");
    rd(8, 32'h0000_01FF, "R1"); rd(26, 32'h0000_0008, "R1");
    rd(27, 32'h1000_0000, "R1"); rd(5, 0, "R1"); rd(14, 0, "R1"); rd(15, 0, "R1");
    pl(0, "R1");
    // R2 plain storage
    wr(5, 32'hA5A5_5A5A);  rd(5, 32'hA5A5_5A5A, "R2");
    wr(16, 32'h1234_5678); rd(16, 32'h1234_5678, "R2");
    wr(27, 32'hFFFF_FFFF); rd(27, 32'hFFFF_FFFF, "R2");
    wr(0, 32'h0);          rd(0, 32'h0, "R2");
    // R3 set alias
    wr(12, 32'h0000_00F0); rd(14, 32'h0000_00F0, "R3"); rd(12, 32'h0000_00F0, "R3");
    wr(12, 32'h0F00_0003); rd(14, 32'h0F00_00F3, "R3");
    // R4 clear alias
    wr(13, 32'h0000_0030); rd(14, 32'h0F00_00C3, "R4"); rd(13, 32'h0000_0030, "R4");
    wr(13, 32'hFFFF_0000); rd(14, 32'h0000_00C3, "R4");
    // R5 ignored writes
    wr(14, 32'hFFFF_FFFF); rd(14, 32'h0000_00C3, "R5");
    irq_pending = 32'h0000_0005; tick();
    wr(15, 32'h0000_DEAD); rd(15, 32'h0000_0005, "R5");
    // R6 status follows pending
    irq_pending = 32'h8000_0001; tick(); rd(15, 32'h8000_0001, "R6");
    irq_pending = 32'h0; tick(); rd(15, 32'h0, "R6");
    // R8 bit already set / data bit clear
    wr(1, 32'h0000_FFFF); pl(0, "R8"); rd(1, 32'h0000_FFFF, "R8");
    wr(1, 32'h0000_0000); pl(0, "R8");
    // R7 rising edge
    wr(1, 32'h0000_0004); pl(1, "R7"); pl(0, "R7"); rd(1, 32'h0000_0004, "R7");
    wr(1, 32'h0000_0004); pl(0, "R8");
    // R9 unmapped
    wr(29, 32'h0000_0011); rd(29, 0, "R9"); rd(28, 0, "R9");
    rd(5, 32'hA5A5_5A5A, "R9"); rd(14, 32'h0000_00C3, "R9");
    tick();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule